// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial slave that holds six 8-bit configuration registers for a clock buffer. A fast system clock oversamples the serial clock and data lines through two-flop synchronizers. Start and stop conditions are recognised from data edges that happen while the serial clock is high. The slave never drives the data line high. It only pulls it low, so the pin works as open-drain.

A write always has the same shape. The master sends the write address, then a command byte and then a byte-count byte; the slave acknowledges both and throws their values away. After that, data bytes fill the registers from index 0 upward, and a stop condition can end the transfer after any complete byte. A read starts with the read address. The slave then sends the byte count (6), followed by every register from index 0 upward, until the master stops acknowledging. The register contents leave the block in parallel to drive the output-control logic.

Top module: `cfgSerialSlave`

## Requirements
- R1: The slave acknowledges an address byte equal to 0xD2 (write) or 0xD3 (read), by holding SDA low during the ninth clock. It leaves SDA released during the ninth clock for any other address byte.
- R2: On a write, the two bytes that follow the address are acknowledged and do not change any register.
- R3: Write data bytes after the first two go into register 0, then register 1, and so on, one register per byte. Each byte is acknowledged, and a register changes only while the synchronized SCL is low.
- R4: A stop after any complete byte ends the write. Registers loaded in that transfer keep their new values, and the rest keep their previous values.
- R5: On a read, the slave sends the byte 6 and then registers 0 to 5, MSB first, one byte per acknowledged ninth clock.
- R6: While reset is asserted, the registers take the values reg0=0xFF, reg1=0xC0, reg2=0xFF, reg3=0xFF, reg4=0xFF, reg5=0x06. The parallel output carries reg0 in bits 7:0 and reg5 in bits 47:40.
- R7: A write data byte aimed at register 5, and any data byte beyond register 5, is acknowledged and discarded.
- R8: After an address byte that does not match, the slave acknowledges nothing and writes nothing until the next start or stop condition.
- R9: A repeated start aborts the current transfer and begins address reception again. Bytes already written before the repeated start keep their values.
- R10: The slave changes its SDA pull-down only while SCL is low.
- R11: When the master does not acknowledge a byte it has read, the slave releases SDA and sends nothing more until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sdaOe | output | 1 | When 1, pulls the SDA pin low |
| regFile | output | 48 | Register contents, reg0 in bits 7:0 up to reg5 in bits 47:40 |

## Verification
Three situations are hard to reach from the ports. The first is a repeated start placed right after a data byte has been acknowledged. At that moment the slave has just released SDA and has already written the byte, so the next address has to be taken as a fresh transfer without losing that write. The bench reaches this with a master task that raises SDA during the low phase that follows the ninth clock, raises SCL, and then lowers SDA. The second is a read that the master cuts short with a not-acknowledge after the count byte; there the bench checks the released line before it sends the stop. The third is a rejected address followed by a byte equal to the valid write address. This shows that the slave stays deaf until the next stop.

// File: rtl/cfgSerialPkg.sv
package cfgSerialPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       rxShift;   // sample one bit into receive shifter
    logic       regWr;     // load receive byte into register regSel
    logic [3:0] regSel;
    logic       txLoad;    // load transmit shifter: 0 = count, n = register n-1
    logic [3:0] txSel;
    logic       txShift;   // advance transmit shifter by one bit
  } dpStrobes_t;

endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      dout   <= '1;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/cfgSerialData.sv
module cfgSerialData
  import cfgSerialPkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 48'h06FF_FFFF_C0FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaSync,
  input  dpStrobes_t            stb,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regFile
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic [7:0] regArr [NUM_REGS];
  logic [7:0] txByte;
  logic [7:0] txNext;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 regArr[i] <= RESET_VALS[i*8 +: 8];
      else if (stb.regWr && stb.regSel == 4'(i)) regArr[i] <= rxByte;
    end
    assign regFile[i*8 +: 8] = regArr[i];
  end

  always_comb begin
    txNext = 8'hFF;
    if (stb.txSel == 4'd0) txNext = COUNT_BYTE;
    for (int i = 0; i < NUM_REGS; i++)
      if (stb.txSel == 4'(i + 1)) txNext = regArr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '1;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[6:0], sdaSync};
      if (stb.txLoad)       txByte <= txNext;
      else if (stb.txShift) txByte <= {txByte[6:0], 1'b1};
    end
  end

  assign txMsb = txByte[7];
endmodule

// File: rtl/cfgSerialCtrl.sv
module cfgSerialCtrl
  import cfgSerialPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         WR_REGS  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclSync,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobes_t stb,
  output logic       sdaOe
);
  localparam logic [3:0] HDR_BYTES = 4'd2;
  localparam logic [3:0] WR_LIMIT  = 4'(WR_REGS);

  busState_e  state;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt, byteIdx, byteNext, dataIdx;
  logic       addrPhase, isRead, ackOk;
  logic       sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign byteNext = (byteIdx == 4'hF) ? byteIdx : byteIdx + 4'd1;
  assign dataIdx  = byteIdx - HDR_BYTES;

  always_comb begin
    stb = '0;
    if (!startDet && !stopDet) begin
      stb.rxShift = (state == ST_RX) && sclRise;
      if (state == ST_RX && sclFall && bitCnt == 4'd8 && !addrPhase &&
          byteIdx >= HDR_BYTES && dataIdx < WR_LIMIT) begin
        stb.regWr  = 1'b1;
        stb.regSel = dataIdx;
      end
      if ((state == ST_ACKOUT && sclFall && isRead) ||
          (state == ST_TXACK && sclFall && ackOk)) begin
        stb.txLoad = 1'b1;
        stb.txSel  = byteIdx;
      end
      stb.txShift = (state == ST_TX) && sclFall && (bitCnt != 4'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      bitCnt    <= '0;
      byteIdx   <= '0;
      addrPhase <= 1'b0;
      isRead    <= 1'b0;
      ackOk     <= 1'b0;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
      if (startDet) begin
        state     <= ST_RX;
        bitCnt    <= '0;
        addrPhase <= 1'b1;
        isRead    <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_RX: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (addrPhase) begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  state     <= ST_ACKOUT;
                  isRead    <= rxByte[0];
                  byteIdx   <= '0;
                  addrPhase <= 1'b0;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                state   <= ST_ACKOUT;
                byteIdx <= byteNext;
              end
            end
          end
          ST_ACKOUT: if (sclFall) begin
            if (isRead) begin
              state   <= ST_TX;
              byteIdx <= byteNext;
            end else begin
              state <= ST_RX;
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_TXACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_TXACK: begin
            if (sclRise) ackOk <= ~sdaSync;
            else if (sclFall) begin
              if (ackOk) begin
                state   <= ST_TX;
                byteIdx <= byteNext;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  assign sdaOe = (state == ST_ACKOUT) || (state == ST_TX && !txMsb);
endmodule

// File: rtl/cfgSerialSlave.sv
module cfgSerialSlave
  import cfgSerialPkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter int         WR_REGS  = 5,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 48'h06FF_FFFF_C0FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFile
);
  logic [1:0] syncOut;
  logic       sclSync, sdaSync, txMsb;
  logic [7:0] rxByte;
  dpStrobes_t stb;

  cfgSync #(.WIDTH(2)) uSync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(syncOut)
  );
  assign sclSync = syncOut[1];
  assign sdaSync = syncOut[0];

  cfgSerialCtrl #(.DEV_ADDR(DEV_ADDR), .WR_REGS(WR_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe)
  );

  cfgSerialData #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS)) uData (
    .clk(clk), .rstN(rstN), .sdaSync(sdaSync), .stb(stb),
    .rxByte(rxByte), .txMsb(txMsb), .regFile(regFile)
  );
endmodule

// File: rtl/cfgSerialChk.sv
module cfgSerialChk #(
  parameter int NUM_REGS = 6,
  parameter int WR_REGS  = 5,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 48'h06FF_FFFF_C0FF
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclSync,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regFile
);
  logic [NUM_REGS*8-1:0] prevRegs;
  logic [NUM_REGS-1:0]   chgMask;

  always_ff @(posedge clk) prevRegs <= regFile;

  always_comb
    for (int i = 0; i < NUM_REGS; i++)
      chgMask[i] = regFile[i*8 +: 8] != prevRegs[i*8 +: 8];

  AST_RESET_LOADS_DEFAULTS: assert property (@(posedge clk) !rstN |=> regFile == RESET_VALS); // R6

  AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rstN) $countones(chgMask) <= 1); // R3

  AST_REG_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN) !$stable(regFile) |-> !sclSync); // R3

  AST_SDA_MOVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN) !$stable(sdaOe) |-> !sclSync); // R10

  for (genvar p = WR_REGS; p < NUM_REGS; p++) begin : gProt
    AST_PROTECTED_REG_STABLE: assert property (@(posedge clk) disable iff (!rstN) $stable(regFile[p*8 +: 8])); // R7
  end
endmodule

bind cfgSerialSlave cfgSerialChk #(
  .NUM_REGS(NUM_REGS), .WR_REGS(WR_REGS), .RESET_VALS(RESET_VALS)
) uChk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOe(sdaOe), .regFile(regFile)
);

// File: tb/sim_cfgSerialSlave.sv
module sim_cfgSerialSlave;
  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic [47:0] regFile;
  wire         sdaBus = sdaM & ~sdaOe;

  int checks = 0, errors = 0, regMis = 0, r10Bad = 0;
  logic [7:0] expRegs [6];
  logic       cmpOn = 1'b0;
  logic       prevOe = 1'b0;

  always #2 clk = ~clk;

  cfgSerialSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regFile(regFile)
  );

  // per-clock comparison against the behavioural register model
  always @(negedge clk) begin
    if (cmpOn)
      for (int i = 0; i < 6; i++)
        if (regFile[i*8 +: 8] !== expRegs[i]) regMis++;
    if (rstN && sdaOe !== prevOe && sclM) r10Bad++;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < 6; i++) chk(tag, 32'(regFile[i*8 +: 8]), 32'(expRegs[i]));
  endtask

  task automatic startC;
    sdaM = 1; sclM = 1; cyc(2*QTR); sdaM = 0; cyc(2*QTR); sclM = 0; cyc(QTR);
  endtask

  task automatic rstartC;
    sdaM = 1; cyc(QTR); sclM = 1; cyc(2*QTR); sdaM = 0; cyc(2*QTR); sclM = 0; cyc(QTR);
  endtask

  task automatic stopC;
    sdaM = 0; cyc(QTR); sclM = 1; cyc(2*QTR); sdaM = 1; cyc(2*QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; cyc(QTR); sclM = 1; cyc(2*QTR); sclM = 0; cyc(QTR);
    end
    sdaM = 1; cyc(QTR); sclM = 1; cyc(QTR);
    acked = (sdaBus == 1'b0);
    cyc(QTR); sclM = 0; cyc(QTR);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      cyc(QTR); sclM = 1; cyc(QTR); b[i] = sdaBus; cyc(QTR); sclM = 0; cyc(QTR);
    end
    sdaM = ackIt ? 1'b0 : 1'b1;
    cyc(QTR); sclM = 1; cyc(2*QTR); sclM = 0; cyc(QTR);
    sdaM = 1;
  endtask

  task automatic doWrite(input logic [7:0] d [8], input int n, input string tag);
    logic a;
    cmpOn = 0;
    startC;
    sendByte(8'hD2, a);  chk("R1 write address ack", 32'(a), 1);
    sendByte(8'h5A, a);  chk("R2 command byte ack", 32'(a), 1);
    sendByte(8'hC3, a);  chk("R2 count byte ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], a);
      chk((k < 5) ? "R3 data byte ack" : "R7 discarded byte ack", 32'(a), 1);
      if (k < 5) expRegs[k] = d[k];
    end
    stopC; cyc(4);
    checkRegs(tag);
    cmpOn = 1;
  endtask

  task automatic doRead(input int n);
    logic a;
    logic [7:0] b;
    cmpOn = 0;
    startC;
    sendByte(8'hD3, a);  chk("R1 read address ack", 32'(a), 1);
    recvByte(n > 0, b);  chk("R5 count byte", 32'(b), 6);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      chk("R5 read register", 32'(b), 32'(expRegs[k]));
    end
    stopC; cyc(4);
    cmpOn = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] d [8];
    expRegs = '{8'hFF, 8'hC0, 8'hFF, 8'hFF, 8'hFF, 8'h06};
    cyc(6); rstN = 1; cyc(6);
    checkRegs("R6 reset values");
    chk("R10 SDA released after reset", 32'(sdaBus), 1);
    cmpOn = 1;

    // header only: nothing changes
    d = '{default: 8'h00};
    doWrite(d, 0, "R2 header bytes discarded");

    // partial write then stop
    d = '{8'hAA, 8'h55, 0, 0, 0, 0, 0, 0};
    doWrite(d, 2, "R4 partial write");
    doRead(6);

    // full write including protected register and one extra
    d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h5E, 8'h77, 0};
    doWrite(d, 7, "R7 protected register");
    doRead(6);

    // unmatched address, then a valid-looking byte
    cmpOn = 0;
    startC;
    sendByte(8'hA4, a); chk("R1 unmatched address not acked", 32'(a), 0);
    sendByte(8'hD2, a); chk("R8 ignored byte not acked", 32'(a), 0);
    sendByte(8'h00, a); chk("R8 ignored data not acked", 32'(a), 0);
    stopC; cyc(4);
    checkRegs("R8 no write while ignoring");
    cmpOn = 1;

    // repeated start after a data byte
    cmpOn = 0;
    startC;
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h3C, a); chk("R9 data before restart ack", 32'(a), 1);
    expRegs[0] = 8'h3C;
    rstartC;
    sendByte(8'hD3, a); chk("R9 address after restart ack", 32'(a), 1);
    recvByte(1'b1, b);  chk("R9 count after restart", 32'(b), 6);
    recvByte(1'b0, b);  chk("R9 register kept across restart", 32'(b), 8'h3C);
    stopC; cyc(4);
    checkRegs("R9 registers after restart");
    cmpOn = 1;

    // master refuses after the count byte
    cmpOn = 0;
    startC;
    sendByte(8'hD3, a);
    recvByte(1'b0, b);  chk("R11 count before refusal", 32'(b), 6);
    cyc(QTR);
    chk("R11 SDA released after refusal", 32'(sdaBus), 1);
    recvByte(1'b0, b);  chk("R11 nothing sent after refusal", 32'(b), 8'hFF);
    stopC; cyc(4);
    cmpOn = 1;
    cyc(20);

    chk("R4 per-clock register model", 32'(regMis), 0);
    chk("R10 SDA moved while SCL high", 32'(r10Bad), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule